// File: doc/BRIEF.md
# DDR SDRAM Supply-Current Command Pattern Generator

This block produces free-running, cycle-exact DDR SDRAM command loops for measuring supply current. It drives the command code, bank, address, an auto-precharge flag and a parallel write-data word on every clock. No host requests are involved. The only inputs are clock, reset, enable, a mode select and a speed-grade select.

There are two modes. In single-bank mode, bank 0 cycles through activate, read and precharge, and the loop is sized to the row-cycle time of the selected grade. In four-bank mode, activates to banks 0 to 3 are interleaved, each followed by a read that closes its row by itself. Row and column addresses come from an internal LFSR that steps on every access. The data word flips half of its bits on every read burst. A loop-start pulse marks the first cycle of each loop, so that period and slot positions can be checked from outside.

Top module: `curtest_pattern_gen`

## Requirements
- R1: While reset is asserted or enable is low, the outputs hold cmd=DESEL, bank=0, addr=0, autoPre=0 and loopStart=0. The first rising edge that sees enable high issues ACT at loop slot 0, and the output shows it after that edge.
- R2: cmd is 3 bits: 0 DESEL, 1 ACT, 2 RD, 3 WR, 4 PRE. Every slot with no other command carries DESEL, and WR is never issued by either loop.
- R3: Single-bank mode (modeSel=0) uses bank 0 only. ACT is at slot 0, RD at slot 3 and PRE at slot tRAS. The loop period is tRC, and all other slots are DESEL.
- R4: gradeSel 0 (133 MHz, CL2.5) and 1 (133 MHz, CL2) give tRAS=6 and tRC=9. gradeSel 2 (166 MHz) gives 7 and 10. gradeSel 3 (200 MHz) gives 8 and 11.
- R5: Four-bank mode (modeSel=1) repeats a 10-slot loop for every grade. ACT to bank b is at slot 2b, RD to bank b is at slot 2b+3 (b=0..3), and slots 1 and 8 are DESEL.
- R6: In four-bank mode every RD has addr[10]=1 and autoPre=1, and no PRE is issued. In single-bank mode RD has addr[10]=0 and autoPre=0, and PRE has addr=0 and bank=0. autoPre is 0 on every non-RD cycle.
- R7: A 16-bit Fibonacci LFSR, seeded with 16'hACE1 at reset, computes feedback = s[15]^s[14]^s[12]^s[3], and its next state is {s[14:0], feedback}. It steps once per ACT or RD. ACT drives addr = s[12:0]. RD drives addr[8:2] = s[8:2], addr[1:0] = 0 and all other bits 0 apart from bit 10 (R6). Each command uses the value held before the step.
- R8: wrData resets to 0. On the edge that issues a RD it is XORed with a mask that has every even bit set (16'h5555 at width 16), so exactly half its bits change. Otherwise it holds.
- R9: A change of modeSel or gradeSel made in the middle of a loop does not alter that loop. The inputs are sampled in slot 0 of each loop.
- R10: loopStart is 1 exactly in the cycle that shows slot 0 (the bank-0 ACT) of each loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the pattern. Low forces DESEL and restarts at slot 0 |
| modeSel | input | 1 | 0 single-bank, 1 four-bank interleave |
| gradeSel | input | 2 | Speed-grade select (R4) |
| cmd | output | 3 | Command code (R2) |
| bank | output | 2 | Bank address |
| addr | output | 13 | Row or column address; bit 10 requests auto-precharge on reads |
| autoPre | output | 1 | High on a read that closes its row |
| wrData | output | 16 | Test data word |
| loopStart | output | 1 | First cycle of each loop |

## Verification
The hardest condition to reach is a mode or grade change that arrives in the middle of a running loop, because it must leave that loop intact and take effect only at the next loop. The stimulus changes the grade partway through a 200 MHz single-bank loop, and the mode partway through a four-bank loop, with enable held high. The next loop then starts without a gap, and the expected stream follows the old settings up to the wrap. A separate sequence drops enable partway through a loop, then re-enables, to confirm that the loop restarts at slot 0 with the LFSR and data state carried over.

// File: rtl/curtest_pkg.sv
package curtest_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4
  } cmdE;

  // strobes from the sequencer to the datapath, valid for one cycle
  typedef struct packed {
    logic       issueAct;
    logic       issueRd;
    logic       issuePre;
    logic [1:0] bank;
    logic       autoPre;
    logic       loopFirst;
  } strobeT;

  // active-to-precharge clocks per grade
  function automatic int unsigned rasOf(input logic [1:0] g);
    case (g)
      2'd2:    return 7;
      2'd3:    return 8;
      default: return 6;
    endcase
  endfunction

  // row cycle clocks per grade
  function automatic int unsigned rcOf(input logic [1:0] g);
    case (g)
      2'd2:    return 10;
      2'd3:    return 11;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/curtest_ctrl.sv
module curtest_ctrl
  import curtest_pkg::*;
#(
  parameter int T_RCD  = 3,
  parameter int T_RRD  = 2,
  parameter int N_BANK = 4,
  parameter int POS_W  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       modeSel,
  input  logic [1:0] gradeSel,
  output strobeT     strb
);

  localparam int FOUR_LEN = (N_BANK - 1) * T_RRD + T_RCD + 1;

  logic [POS_W-1:0] pos;
  logic             curMode;
  logic [1:0]       curGrade;
  logic             effMode;
  logic [1:0]       effGrade;
  logic [POS_W-1:0] lastPos;
  logic [POS_W-1:0] rasPos;

  // settings are taken live in slot 0 and held for the rest of the loop
  always_comb begin
    effMode  = (pos == '0) ? modeSel  : curMode;
    effGrade = (pos == '0) ? gradeSel : curGrade;
    rasPos   = POS_W'(rasOf(effGrade));
    if (effMode) lastPos = POS_W'(FOUR_LEN - 1);
    else         lastPos = POS_W'(rcOf(effGrade) - 1);
  end

  always_comb begin
    strb = '0;
    if (enable) begin
      strb.loopFirst = (pos == '0);
      if (!effMode) begin
        if (pos == '0)                 strb.issueAct = 1'b1;
        else if (pos == POS_W'(T_RCD)) strb.issueRd  = 1'b1;
        else if (pos == rasPos)        strb.issuePre = 1'b1;
      end else begin
        for (int b = 0; b < N_BANK; b++) begin
          if (pos == POS_W'(b * T_RRD)) begin
            strb.issueAct = 1'b1;
            strb.bank     = 2'(b);
          end
          if (pos == POS_W'(b * T_RRD + T_RCD)) begin
            strb.issueRd = 1'b1;
            strb.bank    = 2'(b);
            strb.autoPre = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      curMode  <= 1'b0;
      curGrade <= 2'd0;
    end else begin
      if (!enable || pos == lastPos) pos <= '0;
      else                           pos <= pos + 1'b1;
      if (pos == '0) begin
        curMode  <= modeSel;
        curGrade <= gradeSel;
      end
    end
  end

  // R3: slot counter never runs past the loop end
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pos <= lastPos);

  // R9: latched settings do not move inside a loop
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pos != '0 && $past(pos) != '0) |-> ($stable(curMode) && $stable(curGrade)));

endmodule

// File: rtl/curtest_dpath.sv
module curtest_dpath
  import curtest_pkg::*;
#(
  parameter int          ROW_W     = 13,
  parameter int          COL_W     = 9,
  parameter int          DW        = 16,
  parameter int          AP_BIT    = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  output logic [2:0]       cmd,
  output logic [1:0]       bank,
  output logic [ROW_W-1:0] addr,
  output logic             autoPre,
  output logic [DW-1:0]    wrData,
  output logic             loopStart
);

  localparam logic [DW-1:0] TOGGLE = {(DW / 2){2'b01}};

  logic [15:0]      lfsr;
  logic             fb;
  logic [ROW_W-1:0] rdAddr;
  logic             access;

  always_comb begin
    fb     = lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3];
    access = strb.issueAct | strb.issueRd;
    rdAddr = '0;
    rdAddr[COL_W-1:2] = lfsr[COL_W-1:2];
    rdAddr[AP_BIT]    = strb.autoPre;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr      <= LFSR_SEED;
      cmd       <= CMD_DESEL;
      bank      <= '0;
      addr      <= '0;
      autoPre   <= 1'b0;
      wrData    <= '0;
      loopStart <= 1'b0;
    end else begin
      loopStart <= strb.loopFirst;
      autoPre   <= strb.issueRd & strb.autoPre;
      bank      <= access ? strb.bank : 2'd0;
      if (strb.issueAct) begin
        cmd  <= CMD_ACT;
        addr <= lfsr[ROW_W-1:0];
      end else if (strb.issueRd) begin
        cmd  <= CMD_RD;
        addr <= rdAddr;
      end else if (strb.issuePre) begin
        cmd  <= CMD_PRE;
        addr <= '0;
      end else begin
        cmd  <= CMD_DESEL;
        addr <= '0;
      end
      if (access)       lfsr   <= {lfsr[14:0], fb};
      if (strb.issueRd) wrData <= wrData ^ TOGGLE;
    end
  end

  // R7: generator never locks up at zero
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

endmodule

// File: rtl/curtest_pattern_gen.sv
module curtest_pattern_gen
  import curtest_pkg::*;
#(
  parameter int T_RCD  = 3,
  parameter int T_RRD  = 2,
  parameter int N_BANK = 4,
  parameter int POS_W  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int DW     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeSel,
  input  logic [1:0]       gradeSel,
  output logic [2:0]       cmd,
  output logic [1:0]       bank,
  output logic [ROW_W-1:0] addr,
  output logic             autoPre,
  output logic [DW-1:0]    wrData,
  output logic             loopStart
);

  strobeT strb;

  curtest_ctrl #(
    .T_RCD(T_RCD), .T_RRD(T_RRD), .N_BANK(N_BANK), .POS_W(POS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .gradeSel(gradeSel), .strb(strb)
  );

  curtest_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmd(cmd), .bank(bank),
    .addr(addr), .autoPre(autoPre), .wrData(wrData), .loopStart(loopStart)
  );

  p_off_desel_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (cmd == CMD_DESEL && !loopStart));

  p_start_act_r10: assert property (@(posedge clk) disable iff (!rstN)
    loopStart |-> (cmd == CMD_ACT && bank == 2'd0));

  p_autopre_rd_r6: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmd == CMD_RD && addr[10]));

  p_pre_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRE) |-> (addr == '0 && bank == 2'd0 && !autoPre));

  p_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd != CMD_WR);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_RD) |-> $stable(wrData));

  p_data_flip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_RD) |-> ($countones(wrData ^ $past(wrData)) == DW / 2));

endmodule

// File: tb/curtest_pattern_gen_tb_top.sv
module curtest_pattern_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        modeSel = 1'b0;
  logic [1:0]  gradeSel = 2'd0;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [12:0] addr;
  logic        autoPre;
  logic [15:0] wrData;
  logic        loopStart;

  always #2.5 clk = ~clk;

  curtest_pattern_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .gradeSel(gradeSel), .cmd(cmd), .bank(bank), .addr(addr),
    .autoPre(autoPre), .wrData(wrData), .loopStart(loopStart)
  );

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] addr;
    logic        ap;
    logic        ls;
    logic [15:0] data;
    string       tag;
  } expT;

  expT q[$];
  int total = 0;
  int bad = 0;
  logic [15:0] mLfsr = 16'hACE1;
  logic [15:0] mData = 16'h0000;

  function automatic logic [15:0] stepLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic int loopLen(input logic m, input logic [1:0] g);
    if (m) return 10;
    case (g)
      2'd2: return 10;
      2'd3: return 11;
      default: return 9;
    endcase
  endfunction

  // expected command for a slot (R3, R4, R5); cmd codes per R2
  task automatic pushSlot(input logic m, input logic [1:0] g, input int p, input string tag);
    expT e;
    int ras;
    ras = (g == 2'd2) ? 7 : (g == 2'd3) ? 8 : 6;
    e.cmd = 3'd0; e.bank = 2'd0; e.addr = '0; e.ap = 1'b0; e.ls = (p == 0); e.tag = tag;
    if (!m) begin
      if (p == 0) e.cmd = 3'd1;
      else if (p == 3) e.cmd = 3'd2;
      else if (p == ras) e.cmd = 3'd4;
    end else begin
      case (p)
        0: begin e.cmd = 3'd1; e.bank = 2'd0; end
        2: begin e.cmd = 3'd1; e.bank = 2'd1; end
        3: begin e.cmd = 3'd2; e.bank = 2'd0; end
        4: begin e.cmd = 3'd1; e.bank = 2'd2; end
        5: begin e.cmd = 3'd2; e.bank = 2'd1; end
        6: begin e.cmd = 3'd1; e.bank = 2'd3; end
        7: begin e.cmd = 3'd2; e.bank = 2'd2; end
        9: begin e.cmd = 3'd2; e.bank = 2'd3; end
        default: ;
      endcase
    end
    if (e.cmd == 3'd1) begin
      e.addr = mLfsr[12:0];
      mLfsr = stepLfsr(mLfsr);
    end else if (e.cmd == 3'd2) begin
      e.addr[8:2] = mLfsr[8:2];
      e.addr[10] = m;   // R6
      e.ap = m;
      mLfsr = stepLfsr(mLfsr);
      mData = mData ^ 16'h5555;
    end
    e.data = mData;
    q.push_back(e);
  endtask

  // driver: enable the pattern for nCyc cycles; optional mid-loop input change (R9)
  task automatic runPat(input logic m, input logic [1:0] g, input int nCyc, input string tag,
                        input int chgAt, input logic chgMode, input logic [1:0] chgGrade);
    int len;
    len = loopLen(m, g);
    for (int c = 0; c < nCyc; c++) pushSlot(m, g, c % len, tag);
    enable = 1'b1; modeSel = m; gradeSel = g;
    for (int c = 0; c < nCyc; c++) begin
      @(negedge clk);
      if (c == chgAt) begin modeSel = chgMode; gradeSel = chgGrade; end
    end
  endtask

  // R1: idle cycles give DESEL, data held
  task automatic idle(input int n);
    expT e;
    for (int c = 0; c < n; c++) begin
      e.cmd = 3'd0; e.bank = 2'd0; e.addr = '0; e.ap = 1'b0; e.ls = 1'b0;
      e.data = mData; e.tag = "R1";
      q.push_back(e);
    end
    enable = 1'b0;
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic fail(input string req, input string what, input int act, input int exp);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  // monitor: pops one expected item per cycle, sampled 1 ns after the edge
  initial begin
    expT e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (cmd !== e.cmd)      fail(e.tag, "cmd (R2)", int'(cmd), int'(e.cmd));
        else if (bank !== e.bank) fail(e.tag, "bank", int'(bank), int'(e.bank));
        else if (addr !== e.addr) fail("R7", "addr", int'(addr), int'(e.addr));
        else if (autoPre !== e.ap) fail("R6", "autoPre", int'(autoPre), int'(e.ap));
        else if (wrData !== e.data) fail("R8", "wrData", int'(wrData), int'(e.data));
        else if (loopStart !== e.ls) fail("R10", "loopStart", int'(loopStart), int'(e.ls));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    total++;
    if (cmd !== 3'd0 || addr !== '0 || wrData !== '0 || loopStart !== 1'b0 || autoPre !== 1'b0)
      fail("R1", "reset outputs", int'(cmd), 0);
    rstN = 1'b1;
    idle(3);
    // R3/R4: single-bank at each grade
    runPat(1'b0, 2'd0, 18, "R3", -1, 1'b0, 2'd0);
    runPat(1'b0, 2'd1, 9,  "R4", -1, 1'b0, 2'd0);
    runPat(1'b0, 2'd2, 20, "R4", -1, 1'b0, 2'd0);
    runPat(1'b0, 2'd3, 22, "R4", -1, 1'b0, 2'd0);
    // R5/R6: four-bank interleave
    runPat(1'b1, 2'd0, 30, "R5", -1, 1'b0, 2'd0);
    runPat(1'b1, 2'd3, 10, "R6", -1, 1'b0, 2'd0);
    // R9: grade change inside a 200 MHz loop, then follow-on loop at new grade
    runPat(1'b0, 2'd3, 11, "R9", 4, 1'b0, 2'd0);
    runPat(1'b0, 2'd0, 9,  "R9", -1, 1'b0, 2'd0);
    // R9: mode change inside a four-bank loop
    runPat(1'b1, 2'd2, 10, "R9", 5, 1'b0, 2'd2);
    runPat(1'b0, 2'd2, 10, "R9", -1, 1'b0, 2'd2);
    // R1: abort mid-loop, idle, restart from slot 0
    runPat(1'b1, 2'd1, 6, "R1", -1, 1'b0, 2'd0);
    idle(5);
    runPat(1'b0, 2'd1, 9, "R1", -1, 1'b0, 2'd0);
    idle(4);
    while (q.size() > 0) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule